// File: doc/BRIEF.md
# Adjustable PTP Time-of-Day Counter

This block keeps a running time of day in the form used by precision time protocols: a 48-bit seconds count and a 32-bit nanoseconds count. Internally the sub-second part is an accumulator in units of 1/256 ns. On every cycle of the timing clock it advances by a programmable increment, so the nominal period of that clock can be matched with a fractional-nanosecond resolution. The accumulator wraps at one second, which is 256,000,000,000 units, and each wrap carries into the seconds count.

Software sets a base period and a signed trim together with an apply strobe. The sum, clamped to a legal range, becomes the active increment. A separate strobe replaces the whole time of day at once. A sticky done flag tells a polling CPU that its last request has taken effect. A CPU in another clock domain asks for a snapshot with a one-cycle pulse. It receives seconds and nanoseconds taken from the same timing-clock cycle, together with a valid pulse. The wrap decision uses values prepared when the increment is programmed, so the per-cycle path is one add and a select.

Top module: `ptp_rtc`

## Requirements
- R1: While rst_ni is low, tod_sec_o and tod_ns_o are 0 and adj_done_o is 0.
- R2: On every clk_i edge out of reset without a load, the accumulator grows by the active increment (units of 1/256 ns). tod_ns_o equals the accumulator divided by 256, rounded down.
- R3: When the accumulator would reach 256,000,000,000 or more, it keeps only the remainder above that value, and tod_sec_o rises by exactly 1 on the same edge.
- R4: An edge with adj_req_i high takes period_i (unsigned) plus adj_i (two's complement) as the new active increment. The edge that samples the request still uses the old increment; the new one applies from the following edge.
- R5: The sum in R4 is clamped to the range 1 to 2^INC_W-1, so a large negative trim slows the counter to 1/256 ns per cycle and never stops it or runs it backwards.
- R6: adj_done_o goes to 0 on the edge that samples adj_req_i or load_req_i. It goes to 1 on the next edge if no new request is present, and then holds until the next request.
- R7: An edge with load_req_i high sets the seconds to load_sec_i and the accumulator to load_ns_i times 256, both in the same edge, in place of the increment. load_ns_i must be below 10^9.
- R8: Reset clears the time of day but keeps the active increment, so counting resumes at the programmed rate after reset without a new adjust request.
- R9: A one-cycle rd_req_i pulse in the rd_clk_i domain produces, a few cycles later, a one-cycle rd_valid_o pulse. rd_sec_o and rd_ns_o then hold a time taken in a single clk_i cycle between the request and the valid pulse. Requests made while one is pending are ignored.
- R10: Between loads, the full time (seconds and accumulator) strictly increases on every clk_i edge.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| period_i | input | INC_W | Base period per clock, 1/256 ns units |
| adj_i | input | INC_W | Signed trim added to the base period |
| adj_req_i | input | 1 | Apply period_i + adj_i as the increment |
| load_req_i | input | 1 | Replace the time of day |
| load_sec_i | input | SEC_W | Seconds value to load |
| load_ns_i | input | NS_W | Nanoseconds value to load |
| tod_sec_o | output | SEC_W | Current seconds |
| tod_ns_o | output | NS_W | Current nanoseconds |
| adj_done_o | output | 1 | Last request applied |
| rd_clk_i | input | 1 | CPU read clock |
| rd_req_i | input | 1 | Snapshot request pulse, rd_clk_i domain |
| rd_valid_o | output | 1 | Snapshot ready pulse, rd_clk_i domain |
| rd_sec_o | output | SEC_W | Snapshot seconds |
| rd_ns_o | output | NS_W | Snapshot nanoseconds |

## Verification
Some properties are checked on every cycle: the accumulator stays below one second, the seconds step by at most one, the full time strictly increases between loads, a load lands its seconds with a clean fractional part, the increment is never zero, the done flag follows its clear/set sequence, and a read result is a single pulse holding an in-range nanosecond value. Other behaviour only shows up in the bench's scenarios, where a reference model is compared every cycle: the exact rate after a positive, negative or clamped trim, the carry at the one-second boundary, the increment surviving a reset, and a snapshot falling inside the window between request and valid even across a second wrap.

// File: rtl/ptp_rtc_pkg.sv
package ptp_rtc_pkg;
  localparam longint unsigned ACC_MOD = 64'd256_000_000_000;  // 1 s in 1/256 ns
  localparam int FRAC_W = 8;
  localparam int ACC_W  = $clog2(ACC_MOD);
  localparam int NS_MAX = 999_999_999;
endpackage

// File: rtl/ptp_rtc_inc.sv
module ptp_rtc_inc
  import ptp_rtc_pkg::*;
#(
  parameter int INC_W = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    adj_req_i,
  input  logic        [INC_W-1:0] period_i,
  input  logic signed [INC_W-1:0] adj_i,
  output logic        [ACC_W-1:0] inc_o,
  output logic        [ACC_W-1:0] inc_wrap_o,
  output logic        [ACC_W-1:0] thr_o
);
  localparam int SUM_W = INC_W + 2;
  localparam logic [ACC_W-1:0] MOD_V = ACC_W'(ACC_MOD);

  logic signed [SUM_W-1:0] sum_s;
  logic [INC_W-1:0] eff;
  logic [ACC_W-1:0] inc_q, incm_q, thr_q;

  always_comb begin
    sum_s = $signed({2'b00, period_i}) + $signed({{2{adj_i[INC_W-1]}}, adj_i});
    if (sum_s < $signed(SUM_W'(1)))                       eff = INC_W'(1);
    else if (sum_s > $signed({2'b00, {INC_W{1'b1}}}))     eff = '1;
    else                                                  eff = sum_s[INC_W-1:0];
  end

  // no reset: the programmed rate survives rst_ni
  always_ff @(posedge clk_i) begin
    if (adj_req_i) begin
      inc_q  <= ACC_W'(eff);
      incm_q <= ACC_W'(eff) - MOD_V;   // pre-added wrap increment
      thr_q  <= MOD_V - ACC_W'(eff);   // wrap threshold
    end
  end

  assign inc_o      = inc_q;
  assign inc_wrap_o = incm_q;
  assign thr_o      = thr_q;

  AST_INC_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adj_req_i |=> (inc_o != '0)); // R5
endmodule

// File: rtl/ptp_rtc_acc.sv
module ptp_rtc_acc
  import ptp_rtc_pkg::*;
#(
  parameter int SEC_W = 48,
  parameter int NS_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SEC_W-1:0] load_sec_i,
  input  logic [NS_W-1:0]  load_ns_i,
  input  logic [ACC_W-1:0] inc_i,
  input  logic [ACC_W-1:0] inc_wrap_i,
  input  logic [ACC_W-1:0] thr_i,
  output logic [SEC_W-1:0] sec_o,
  output logic [ACC_W-1:0] acc_o
);
  localparam logic [ACC_W-1:0] MOD_V = ACC_W'(ACC_MOD);
  localparam int NSI_W = ACC_W - FRAC_W;

  logic [SEC_W-1:0] sec_q;
  logic [ACC_W-1:0] acc_q, sum_a, sum_b;
  logic             wrap;

  // both sums and the wrap compare run in parallel
  always_comb begin
    sum_a = acc_q + inc_i;
    sum_b = acc_q + inc_wrap_i;
    wrap  = (acc_q >= thr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      acc_q <= '0;
    end else if (load_i) begin
      sec_q <= load_sec_i;
      acc_q <= {load_ns_i[NSI_W-1:0], {FRAC_W{1'b0}}};
    end else if (wrap) begin
      sec_q <= sec_q + SEC_W'(1);
      acc_q <= sum_b;
    end else begin
      acc_q <= sum_a;
    end
  end

  assign sec_o = sec_q;
  assign acc_o = acc_q;

  AST_ACC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < MOD_V); // R3
  AST_SEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (sec_q == $past(sec_q) || sec_q == $past(sec_q) + SEC_W'(1))); // R3
  AST_MONOTONIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ({sec_q, acc_q} > $past({sec_q, acc_q}))); // R10
  AST_LOAD_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sec_q == $past(load_sec_i) && acc_q[FRAC_W-1:0] == '0)); // R7
endmodule

// File: rtl/ptp_rtc_rdsync.sv
module ptp_rtc_rdsync
  import ptp_rtc_pkg::*;
#(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 32,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rd_clk_i,
  input  logic             rst_ni,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [NS_W-1:0]  ns_i,
  input  logic             rd_req_i,
  output logic             rd_valid_o,
  output logic [SEC_W-1:0] rd_sec_o,
  output logic [NS_W-1:0]  rd_ns_o
);
  logic              req_tgl_q, busy_q, ack_seen_q, rd_valid_q;
  logic              req_seen_q, ack_tgl_q;
  logic [SYNC_N-1:0] ack_sync_q, req_sync_q;
  logic [SEC_W-1:0]  snap_sec_q, rd_sec_q;
  logic [NS_W-1:0]   snap_ns_q, rd_ns_q;

  // read domain: issue toggle, wait for returned toggle
  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_tgl_q  <= 1'b0;
      busy_q     <= 1'b0;
      ack_seen_q <= 1'b0;
      rd_valid_q <= 1'b0;
      ack_sync_q <= '0;
      rd_sec_q   <= '0;
      rd_ns_q    <= '0;
    end else begin
      rd_valid_q <= 1'b0;
      ack_sync_q <= {ack_sync_q[SYNC_N-2:0], ack_tgl_q};
      if (ack_sync_q[SYNC_N-1] != ack_seen_q) begin
        ack_seen_q <= ack_sync_q[SYNC_N-1];
        busy_q     <= 1'b0;
        rd_valid_q <= 1'b1;
        rd_sec_q   <= snap_sec_q;  // snapshot is static while busy
        rd_ns_q    <= snap_ns_q;
      end else if (rd_req_i && !busy_q) begin
        req_tgl_q <= ~req_tgl_q;
        busy_q    <= 1'b1;
      end
    end
  end

  // timing domain: capture both fields in one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_sync_q <= '0;
      req_seen_q <= 1'b0;
      ack_tgl_q  <= 1'b0;
      snap_sec_q <= '0;
      snap_ns_q  <= '0;
    end else begin
      req_sync_q <= {req_sync_q[SYNC_N-2:0], req_tgl_q};
      if (req_sync_q[SYNC_N-1] != req_seen_q) begin
        req_seen_q <= req_sync_q[SYNC_N-1];
        snap_sec_q <= sec_i;
        snap_ns_q  <= ns_i;
        ack_tgl_q  <= ~ack_tgl_q;
      end
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_sec_o   = rd_sec_q;
  assign rd_ns_o    = rd_ns_q;

  AST_RD_PULSE: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o); // R9
  AST_RD_NS_RANGE: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (rd_ns_o <= NS_W'(NS_MAX))); // R9
endmodule

// File: rtl/ptp_rtc.sv
module ptp_rtc
  import ptp_rtc_pkg::*;
#(
  parameter int INC_W  = 24,
  parameter int SEC_W  = 48,
  parameter int NS_W   = 32,
  parameter int SYNC_N = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic        [INC_W-1:0] period_i,
  input  logic signed [INC_W-1:0] adj_i,
  input  logic                    adj_req_i,
  input  logic                    load_req_i,
  input  logic        [SEC_W-1:0] load_sec_i,
  input  logic        [NS_W-1:0]  load_ns_i,
  output logic        [SEC_W-1:0] tod_sec_o,
  output logic        [NS_W-1:0]  tod_ns_o,
  output logic                    adj_done_o,
  input  logic                    rd_clk_i,
  input  logic                    rd_req_i,
  output logic                    rd_valid_o,
  output logic        [SEC_W-1:0] rd_sec_o,
  output logic        [NS_W-1:0]  rd_ns_o
);
  logic [ACC_W-1:0] inc, inc_wrap, thr, acc;
  logic [SEC_W-1:0] sec;
  logic             pend_q, done_q, req_any;

  ptp_rtc_inc #(.INC_W(INC_W)) u_inc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adj_req_i  (adj_req_i),
    .period_i   (period_i),
    .adj_i      (adj_i),
    .inc_o      (inc),
    .inc_wrap_o (inc_wrap),
    .thr_o      (thr)
  );

  ptp_rtc_acc #(.SEC_W(SEC_W), .NS_W(NS_W)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_req_i),
    .load_sec_i (load_sec_i),
    .load_ns_i  (load_ns_i),
    .inc_i      (inc),
    .inc_wrap_i (inc_wrap),
    .thr_i      (thr),
    .sec_o      (sec),
    .acc_o      (acc)
  );

  assign tod_sec_o = sec;
  assign tod_ns_o  = NS_W'(acc >> FRAC_W);

  assign req_any = adj_req_i | load_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else if (req_any) begin
      pend_q <= 1'b1;
      done_q <= 1'b0;
    end else if (pend_q) begin
      pend_q <= 1'b0;
      done_q <= 1'b1;
    end
  end

  assign adj_done_o = done_q;

  ptp_rtc_rdsync #(.SEC_W(SEC_W), .NS_W(NS_W), .SYNC_N(SYNC_N)) u_rd (
    .clk_i      (clk_i),
    .rd_clk_i   (rd_clk_i),
    .rst_ni     (rst_ni),
    .sec_i      (tod_sec_o),
    .ns_i       (tod_ns_o),
    .rd_req_i   (rd_req_i),
    .rd_valid_o (rd_valid_o),
    .rd_sec_o   (rd_sec_o),
    .rd_ns_o    (rd_ns_o)
  );

  AST_DONE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_any |=> !adj_done_o); // R6
  AST_DONE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_any ##1 !req_any |=> adj_done_o); // R6
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adj_done_o && !req_any |=> adj_done_o); // R6
endmodule

// File: tb/ptp_rtc_tb_top.sv
module ptp_rtc_tb_top;
  localparam longint unsigned MOD = 64'd256_000_000_000;
  localparam int INC_MAX = 16777215;

  logic clk = 1'b0, rd_clk = 1'b0, rst_ni = 1'b0;
  logic [23:0] period = '0;
  logic signed [23:0] adj = '0;
  logic adj_req = 1'b0, load_req = 1'b0, rd_req = 1'b0;
  logic [47:0] load_sec = '0;
  logic [31:0] load_ns = '0;
  logic [47:0] tod_sec, rd_sec;
  logic [31:0] tod_ns, rd_ns;
  logic adj_done, rd_valid;

  int n_chk = 0, n_fail = 0, n_val = 0;
  bit cmp_en = 1'b0;

  // reference model
  longint unsigned m_acc = 0, m_sec = 0;
  longint m_inc = 0;
  bit m_done = 0, m_pend = 0;

  always #10 clk = ~clk;                 // 50 MHz
  initial begin #7; forever #15 rd_clk = ~rd_clk; end

  ptp_rtc dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .period_i(period), .adj_i(adj),
    .adj_req_i(adj_req), .load_req_i(load_req), .load_sec_i(load_sec),
    .load_ns_i(load_ns), .tod_sec_o(tod_sec), .tod_ns_o(tod_ns),
    .adj_done_o(adj_done), .rd_clk_i(rd_clk), .rd_req_i(rd_req),
    .rd_valid_o(rd_valid), .rd_sec_o(rd_sec), .rd_ns_o(rd_ns)
  );

  task automatic chk(string req, longint unsigned act, longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint unsigned m_time();
    return m_sec * 64'd1_000_000_000 + (m_acc >> 8);
  endfunction

  always @(posedge clk) begin
    longint s;
    if (!rst_ni) begin
      m_acc = 0; m_sec = 0; m_done = 0; m_pend = 0;
    end else begin
      if (load_req) begin
        m_sec = load_sec; m_acc = longint'(load_ns) * 256;
      end else begin
        m_acc += m_inc;
        if (m_acc >= MOD) begin m_acc -= MOD; m_sec++; end
      end
      if (adj_req || load_req) begin m_done = 0; m_pend = 1; end
      else if (m_pend) begin m_done = 1; m_pend = 0; end
    end
    if (adj_req) begin
      s = longint'(period) + longint'(adj);
      if (s < 1) s = 1;
      if (s > INC_MAX) s = INC_MAX;
      m_inc = s;
    end
  end

  always @(negedge clk) begin
    if (rst_ni && cmp_en) begin
      chk("R2/R3 seconds", tod_sec, m_sec);
      chk("R2 nanoseconds", tod_ns, m_acc >> 8);
      chk("R6 done flag", adj_done, m_done);
    end
  end

  always @(negedge rd_clk) if (rd_valid) n_val++;

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apply(logic [23:0] p, logic signed [23:0] a);
    @(negedge clk); period = p; adj = a; adj_req = 1'b1;
    @(negedge clk); adj_req = 1'b0;
  endtask

  task automatic do_read(bit twice);
    longint unsigned t0, t1, r;
    int v0;
    bit got = 0;
    v0 = n_val;
    @(negedge rd_clk); t0 = m_time(); rd_req = 1'b1;
    @(negedge rd_clk); rd_req = twice;
    @(negedge rd_clk); rd_req = 1'b0;
    for (int i = 0; i < 30 && !got; i++) begin
      @(negedge rd_clk);
      if (rd_valid) got = 1;
    end
    t1 = m_time();
    r = rd_sec * 64'd1_000_000_000 + rd_ns;
    chk("R9 valid seen", got, 1);
    n_chk++;
    if (r < t0 || r > t1) begin
      n_fail++;
      $display("FAIL R9 snapshot: actual %0d expected within %0d..%0d", r, t0, t1);
    end
    repeat (20) @(negedge rd_clk);
    chk("R9 one result per request", n_val - v0, 1);
  endtask

  initial begin
    longint unsigned a, b;
    // program rate during reset
    cyc(2);
    apply(24'd5120, 24'sd0);
    cyc(1);
    chk("R1 seconds in reset", tod_sec, 0);
    chk("R1 ns in reset", tod_ns, 0);
    chk("R1 done in reset", adj_done, 0);
    rst_ni = 1'b1; cmp_en = 1'b1;
    cyc(5);
    chk("R2 ns after 5 cycles of 20 ns", tod_ns, 100);
    cyc(10);
    // R4, R6: positive trim
    @(negedge clk); period = 24'd5120; adj = 24'sd16; adj_req = 1'b1;
    @(negedge clk); adj_req = 1'b0;
    chk("R6 done cleared by request", adj_done, 0);
    @(negedge clk);
    chk("R6 done set next cycle", adj_done, 1);
    a = tod_ns; cyc(16);
    chk("R4 rate with +16 trim", tod_ns - a, (16 * 5136 + 0) >> 8);
    // R4: negative trim
    apply(24'd5120, -24'sd16);
    cyc(32);
    // R5: clamp low
    apply(24'd5120, -24'sd8388608);
    cyc(1); a = tod_ns; cyc(512);
    chk("R5 clamped to 1/256 ns", tod_ns - a, 2);
    // R5: clamp high
    apply(24'hFFFFFF, 24'sd100);
    cyc(1); a = {16'd0, tod_sec} * 64'd1_000_000_000 + tod_ns; cyc(256);
    b = {16'd0, tod_sec} * 64'd1_000_000_000 + tod_ns;
    chk("R5 clamped to max", b - a, INC_MAX);
    apply(24'd5120, 24'sd0);
    // R7, R3: load then wrap
    @(negedge clk); load_req = 1'b1; load_sec = 48'd7; load_ns = 32'd999_999_900;
    @(negedge clk); load_req = 1'b0;
    chk("R7 loaded seconds", tod_sec, 7);
    chk("R7 loaded ns", tod_ns, 999_999_900);
    cyc(4);
    chk("R3 before wrap", tod_ns, 999_999_980);
    cyc(1);
    chk("R3 seconds carry", tod_sec, 8);
    chk("R3 ns remainder", tod_ns, 0);
    // R9: reads
    do_read(0);
    do_read(1);
    @(negedge clk); load_req = 1'b1; load_sec = 48'd20; load_ns = 32'd999_999_970;
    @(negedge clk); load_req = 1'b0;
    do_read(0);
    do_read(0);
    // R8: reset keeps rate
    apply(24'd5120, 24'sd200);
    cyc(3);
    @(negedge clk); rst_ni = 1'b0;
    cyc(2);
    chk("R8 time cleared", tod_ns, 0);
    rst_ni = 1'b1;
    cyc(10);
    chk("R8 rate kept across reset", tod_ns, (10 * 5320) >> 8);
    cyc(5);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule